// File: doc/BRIEF.md
# Region-tagged frame packer with elastic output buffer

This block gathers cluster words from several readout regions during a frame and, when a frame-start strobe closes that frame, turns them into one packet of 16-bit words. The packet opens with a frame header that carries a rolling frame number. Then, for each region that holds data, it carries a region header followed by that region's cluster words. A trailer closes the packet. Regions without hits add nothing, so the packet has no empty slots between the groups of two regions.

Each region writes into its own small buffer while a frame is being collected. A strobe freezes the count of words in every region buffer. The sequencer then drains exactly those words, and words arriving later stay behind for the next frame. Each packet goes into an elastic FIFO that a downstream serializer empties through a valid/ready handshake. This FIFO lets bursts of hits in a few frames ride out on a steady output. The packet size is worked out before the first word is written. If the FIFO cannot take the whole packet, the cluster data of that frame are discarded and only the header and a flagged trailer are written.

Each word is 16 bits and comes with a 2-bit kind code. A cluster word holds a 13-bit pixel address and a 3-bit cluster pattern. The block passes it through without looking at it.

Top module: `frame_packer`

## Requirements
- R1: After reset, out_valid is low and the first packet carries frame number 0.
- R2: Each accepted frame_start strobe produces exactly one packet. Its first word is a frame header (kind 2, data = frame number zero-extended) and its last word is a trailer (kind 3).
- R3: Inside a packet, regions appear in ascending index order. A region with no words emits nothing. A region that has words emits a region header (kind 1, data = region index) just before its words.
- R4: Cluster words come out as kind 0 with all 16 bits unchanged, in the order in which their region received them.
- R5: A word presented on the same cycle as frame_start belongs to the next frame. A word presented on an earlier cycle belongs to the frame being closed.
- R6: Trailer data bit 15 is the drop flag. Bits 14:0 give the number of cluster words the frame held, counting any that were dropped.
- R7: If the free space in the elastic FIFO is smaller than the full packet (2 + regions with data + cluster words), the frame's region headers and cluster words are discarded. The header and a trailer with the drop flag set are still written. Later frames are packed normally.
- R8: The frame number advances by one for each accepted strobe and wraps from 2^FCNT_W-1 to 0.
- R9: While out_valid is high and out_ready is low, out_data and out_kind hold steady. No word is lost or reordered across stalls.
- R10: A word presented to a region whose buffer already holds RG_DEPTH words is discarded and never appears at the output.
- R11: The elastic FIFO is never written while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Strobe that closes the current frame; allowed only while no packet is being built |
| rg_valid | input | N_REG | One write strobe per region |
| rg_data | input | 16*N_REG | Cluster word per region, region r at bits 16r+15:16r |
| out_valid | output | 1 | Elastic FIFO holds a word |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Output word |
| out_kind | output | 2 | 0 cluster, 1 region header, 2 frame header, 3 trailer |

## Verification
The bench builds the block with four regions, region buffers of depth 4, an elastic FIFO of 16 words and a 3-bit frame number. A single worst-case packet of 22 words then exceeds the FIFO, so a stalled consumer plus two frames is enough to force a dropped frame. The frame number wraps after eight frames, and a region buffer overflows after a fifth word. With the default sizes, each of these cases would need hundreds of frames or words.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    K_CLU = 2'd0,
    K_RGN = 2'd1,
    K_FHD = 2'd2,
    K_FTR = 2'd3
  } word_kind_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_FHDR  = 3'd2,
    S_RHDR  = 3'd3,
    S_DATA  = 3'd4,
    S_TRL   = 3'd5
  } seq_state_t;

endpackage

// File: rtl/fpk_fifo.sv
module fpk_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  always_comb begin
    do_wr  = wr_en && (cnt_q != CW'(DEPTH));
    do_rd  = rd_en && (cnt_q != '0);
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_wr) wptr_d = wptr_q + AW'(1);
    if (do_rd) rptr_d = rptr_q + AW'(1);
    cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

  assign rd_data = mem[rptr_q];
  assign count   = cnt_q;

endmodule

// File: rtl/fpk_sequencer.sv
module fpk_sequencer
  import fpk_pkg::*;
#(
  parameter int N_REG     = 4,
  parameter int RG_DEPTH  = 8,
  parameter int OUT_DEPTH = 256,
  parameter int FCNT_W    = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        frame_start,
  input  logic [N_REG-1:0][$clog2(RG_DEPTH+1)-1:0]    rg_count,
  input  logic [N_REG-1:0][WORD_W-1:0]                rg_word,
  output logic [N_REG-1:0]                            rg_pop,
  input  logic [$clog2(OUT_DEPTH+1)-1:0]              ef_count,
  output logic                                        ef_wr,
  output logic [WORD_W+1:0]                           ef_word,
  output logic                                        idle_o,
  output logic [FCNT_W-1:0]                           fcnt_o,
  output logic                                        drop_o
);

  localparam int RG_CW  = $clog2(RG_DEPTH + 1);
  localparam int OUT_CW = $clog2(OUT_DEPTH + 1);
  localparam int RIW    = $clog2(N_REG);
  localparam int TOT_W  = RG_CW + $clog2(N_REG);
  localparam int NZ_W   = $clog2(N_REG + 1);

  seq_state_t                   state_q, state_d;
  logic [N_REG-1:0][RG_CW-1:0]  snap_q, snap_d;
  logic [N_REG-1:0]             pend_q, pend_d;
  logic [TOT_W-1:0]             total_q, total_d;
  logic [NZ_W-1:0]              nz_q, nz_d;
  logic [FCNT_W-1:0]            fcnt_q, fcnt_d;
  logic [FCNT_W-1:0]            fnum_q, fnum_d;
  logic [RIW-1:0]               cur_q, cur_d;
  logic                         drop_q, drop_d;

  logic [TOT_W-1:0]             sum_now;
  logic [NZ_W-1:0]              nz_now;
  logic [N_REG-1:0]             pend_rest;
  logic [RIW-1:0]               lo_all, lo_rest;
  logic [31:0]                  need_w, free_w;

  // current buffer occupancy, summed over regions
  always_comb begin
    sum_now = '0;
    nz_now  = '0;
    for (int r = 0; r < N_REG; r++) begin
      sum_now = sum_now + TOT_W'(rg_count[r]);
      nz_now  = nz_now + NZ_W'(rg_count[r] != '0);
    end
  end

  // lowest pending region, with and without the one being drained
  always_comb begin
    pend_rest = pend_q;
    pend_rest[cur_q] = 1'b0;
    lo_all  = '0;
    lo_rest = '0;
    for (int r = N_REG - 1; r >= 0; r--) begin
      if (pend_q[r])    lo_all  = RIW'(r);
      if (pend_rest[r]) lo_rest = RIW'(r);
    end
  end

  assign need_w = 32'(total_q) + 32'(nz_q) + 32'd2;
  assign free_w = 32'(OUT_DEPTH) - 32'(ef_count);

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    pend_d  = pend_q;
    total_d = total_q;
    nz_d    = nz_q;
    fcnt_d  = fcnt_q;
    fnum_d  = fnum_q;
    cur_d   = cur_q;
    drop_d  = drop_q;
    rg_pop  = '0;
    ef_wr   = 1'b0;
    ef_word = '0;
    unique case (state_q)
      S_IDLE: begin
        if (frame_start) begin
          for (int r = 0; r < N_REG; r++) begin
            snap_d[r] = rg_count[r];
            pend_d[r] = (rg_count[r] != '0);
          end
          total_d = sum_now;
          nz_d    = nz_now;
          fnum_d  = fcnt_q;
          fcnt_d  = fcnt_q + FCNT_W'(1);
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (free_w >= need_w) begin
          drop_d  = 1'b0;
          state_d = S_FHDR;
        end else if (free_w >= 32'd2) begin
          drop_d  = 1'b1;
          state_d = S_FHDR;
        end
      end
      S_FHDR: begin
        ef_wr   = 1'b1;
        ef_word = {K_FHD, WORD_W'(fnum_q)};
        cur_d   = lo_all;
        state_d = (pend_q != '0) ? S_RHDR : S_TRL;
      end
      S_RHDR: begin
        ef_wr   = !drop_q;
        ef_word = {K_RGN, WORD_W'(cur_q)};
        state_d = S_DATA;
      end
      S_DATA: begin
        rg_pop[cur_q] = 1'b1;
        ef_wr         = !drop_q;
        ef_word       = {K_CLU, rg_word[cur_q]};
        snap_d[cur_q] = snap_q[cur_q] - RG_CW'(1);
        if (snap_q[cur_q] == RG_CW'(1)) begin
          pend_d[cur_q] = 1'b0;
          if (pend_rest != '0) begin
            cur_d   = lo_rest;
            state_d = S_RHDR;
          end else begin
            state_d = S_TRL;
          end
        end
      end
      S_TRL: begin
        ef_wr   = 1'b1;
        ef_word = {K_FTR, drop_q, 15'(total_q)};
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      snap_q  <= '0;
      pend_q  <= '0;
      total_q <= '0;
      nz_q    <= '0;
      fcnt_q  <= '0;
      fnum_q  <= '0;
      cur_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
      pend_q  <= pend_d;
      total_q <= total_d;
      nz_q    <= nz_d;
      fcnt_q  <= fcnt_d;
      fnum_q  <= fnum_d;
      cur_q   <= cur_d;
      drop_q  <= drop_d;
    end
  end

  assign idle_o = (state_q == S_IDLE);
  assign fcnt_o = fcnt_q;
  assign drop_o = drop_q;

endmodule

// File: rtl/frame_packer.sv
module frame_packer
  import fpk_pkg::*;
#(
  parameter int N_REG     = 4,
  parameter int RG_DEPTH  = 8,
  parameter int OUT_DEPTH = 256,
  parameter int FCNT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [N_REG-1:0]        rg_valid,
  input  logic [16*N_REG-1:0]     rg_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [15:0]             out_data,
  output logic [1:0]              out_kind
);

  localparam int RG_CW  = $clog2(RG_DEPTH + 1);
  localparam int OUT_CW = $clog2(OUT_DEPTH + 1);
  localparam int EW     = WORD_W + 2;

  logic [1:0]                   rs_q;
  logic                         rst_n_s;
  logic [N_REG-1:0][RG_CW-1:0]  rg_count;
  logic [N_REG-1:0][WORD_W-1:0] rg_word;
  logic [N_REG-1:0]             rg_pop;
  logic [OUT_CW-1:0]            ef_count;
  logic                         ef_wr;
  logic [EW-1:0]                ef_word;
  logic [EW-1:0]                ef_head;
  logic                         ef_full;
  logic                         seq_idle;
  logic [FCNT_W-1:0]            fcnt;
  logic                         drop_flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  for (genvar r = 0; r < N_REG; r++) begin : g_region
    fpk_fifo #(.W(WORD_W), .DEPTH(RG_DEPTH)) u_rbuf (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_en   (rg_valid[r]),
      .wr_data (rg_data[16*r +: 16]),
      .rd_en   (rg_pop[r]),
      .rd_data (rg_word[r]),
      .count   (rg_count[r])
    );
  end

  fpk_sequencer #(
    .N_REG(N_REG), .RG_DEPTH(RG_DEPTH), .OUT_DEPTH(OUT_DEPTH), .FCNT_W(FCNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .frame_start (frame_start),
    .rg_count    (rg_count),
    .rg_word     (rg_word),
    .rg_pop      (rg_pop),
    .ef_count    (ef_count),
    .ef_wr       (ef_wr),
    .ef_word     (ef_word),
    .idle_o      (seq_idle),
    .fcnt_o      (fcnt),
    .drop_o      (drop_flag)
  );

  fpk_fifo #(.W(EW), .DEPTH(OUT_DEPTH)) u_elastic (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (ef_wr),
    .wr_data (ef_word),
    .rd_en   (out_valid && out_ready),
    .rd_data (ef_head),
    .count   (ef_count)
  );

  assign ef_full   = (ef_count == OUT_CW'(OUT_DEPTH));
  assign out_valid = (ef_count != '0);
  assign out_data  = ef_head[WORD_W-1:0];
  assign out_kind  = ef_head[EW-1:WORD_W];

endmodule

// File: rtl/frame_packer_chk.sv
module frame_packer_chk #(
  parameter int N_REG  = 4,
  parameter int FCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              out_valid,
  input logic              out_ready,
  input logic [15:0]       out_data,
  input logic [1:0]        out_kind,
  input logic              ef_wr,
  input logic              ef_full,
  input logic [17:0]       ef_word,
  input logic              seq_idle,
  input logic              frame_start,
  input logic [FCNT_W-1:0] fcnt,
  input logic              drop_flag,
  input logic [N_REG-1:0]  rg_pop
);

  // R11: elastic FIFO never written while full
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    ef_wr |-> !ef_full);

  // R9: stalled output word holds
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));

  // R8: frame number steps by one per accepted strobe
  assert_frame_step_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_start && seq_idle) |=> (fcnt == FCNT_W'($past(fcnt) + 1'b1)));

  // R7: dropped frame writes no region header and no cluster word
  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ef_wr && !ef_word[17]) |-> !drop_flag);

  // R3: at most one region drained at a time, never while idle
  assert_single_drain_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rg_pop != '0) |-> ($onehot0(rg_pop) && !seq_idle));

endmodule

bind frame_packer frame_packer_chk #(.N_REG(N_REG), .FCNT_W(FCNT_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_kind    (out_kind),
  .ef_wr       (ef_wr),
  .ef_full     (ef_full),
  .ef_word     (ef_word),
  .seq_idle    (seq_idle),
  .frame_start (frame_start),
  .fcnt        (fcnt),
  .drop_flag   (drop_flag),
  .rg_pop      (rg_pop)
);

// File: tb/tb_frame_packer.sv
module tb_frame_packer;

  localparam int NR  = 4;
  localparam int RGD = 4;
  localparam int OD  = 16;
  localparam int FW  = 3;

  logic              clk;
  logic              rst_n;
  logic              frame_start;
  logic [NR-1:0]     rg_valid;
  logic [16*NR-1:0]  rg_data;
  logic              out_valid;
  logic              out_ready;
  logic [15:0]       out_data;
  logic [1:0]        out_kind;

  int checks = 0;
  int errors = 0;
  int exp_fc = 0;
  bit collect = 0;

  logic [15:0] rq [NR][$];
  logic [17:0] expq [$];
  logic [17:0] gotq [$];

  frame_packer #(.N_REG(NR), .RG_DEPTH(RGD), .OUT_DEPTH(OD), .FCNT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rg_valid(rg_valid), .rg_data(rg_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_kind(out_kind)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (collect && out_valid && out_ready) gotq.push_back({out_kind, out_data});
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write one word into one region (buffer model keeps RGD words)
  task automatic hit(input int r, input logic [15:0] w);
    rg_valid = '0;
    rg_valid[r] = 1'b1;
    rg_data[16*r +: 16] = w;
    if (rq[r].size() < RGD) rq[r].push_back(w);
    tick();
    rg_valid = '0;
  endtask

  // expected packet from the model, then clear it
  task automatic build(input bit drop);
    int n = 0;
    expq.push_back({2'd2, 16'(exp_fc)});
    for (int r = 0; r < NR; r++) begin
      n += rq[r].size();
      if (!drop && rq[r].size() > 0) begin
        expq.push_back({2'd1, 16'(r)});
        foreach (rq[r][i]) expq.push_back({2'd0, rq[r][i]});
      end
      rq[r].delete();
    end
    expq.push_back({2'd3, drop, 15'(n)});
    exp_fc = (exp_fc + 1) % (1 << FW);
  endtask

  task automatic strobe(input bit drop);
    build(drop);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    repeat (40) tick();
  endtask

  task automatic compare(input string tag);
    repeat (30) tick();
    check({tag, " length"}, gotq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < gotq.size(); i++)
      check(tag, {14'd0, gotq[i]}, {14'd0, expq[i]});
    gotq.delete();
    expq.delete();
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_empty();
    strobe(0);
    compare("R1 R2 empty frame");
  endtask

  task automatic t_single();
    hit(2, 16'hA5C3);
    hit(2, 16'h1FFF);
    strobe(0);
    compare("R4 R6 single region");
  endtask

  task automatic t_order();
    hit(3, 16'h3001);
    hit(0, 16'h0001);
    hit(2, 16'h2001);
    hit(0, 16'h0002);
    hit(3, 16'h3002);
    strobe(0);
    compare("R3 ascending order, empty region skipped");
  endtask

  task automatic t_same_cycle();
    hit(1, 16'h1111);
    build(0);
    rg_valid = 4'b0001;
    rg_data[15:0] = 16'hBEEF;
    rq[0].push_back(16'hBEEF);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    rg_valid = '0;
    repeat (40) tick();
    strobe(0);
    compare("R5 word with strobe goes to next frame");
  endtask

  task automatic t_region_full();
    for (int i = 0; i < 6; i++) hit(1, 16'h4000 + 16'(i));
    strobe(0);
    compare("R10 full region buffer discards");
  endtask

  task automatic t_backpressure();
    hit(0, 16'h7001);
    hit(1, 16'h7002);
    hit(1, 16'h7003);
    hit(3, 16'h7004);
    build(0);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      out_ready = (i % 3 == 0);
      tick();
    end
    out_ready = 1'b1;
    compare("R9 stalls keep stream intact");
  endtask

  task automatic t_overflow();
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) hit(0, 16'h5000 + 16'(i));
    strobe(0);
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < 4; i++) hit(r, 16'h6000 + 16'(r * 16 + i));
    strobe(1);
    hit(3, 16'h6A6A);
    strobe(0);
    out_ready = 1'b1;
    compare("R7 R6 dropped frame flagged, next frame intact");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 9; i++) strobe(0);
    compare("R8 frame number wraps");
  endtask

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0;
    rg_valid = '0;
    rg_data = '0;
    out_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    collect = 1'b1;
    t_reset();
    t_empty();
    t_single();
    t_order();
    t_same_cycle();
    t_region_full();
    t_backpressure();
    t_overflow();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule